// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block keeps the local reservation that load-linked / store-conditional atomics on one core need. A load-exclusive request records the physical granule it touched and arms the reservation. A later store-exclusive to the same granule is allowed to write only if nothing has disturbed the reservation in between. The block answers every store-exclusive with a status bit and a write enable for the memory side. Software retries its loop whenever the status reports failure.

The reservation is dropped by any of these events: a taken interrupt, a return from an exception, an explicit clear request, a write by another agent that hits the reserved granule, or any store-exclusive, whether it succeeds or fails. Addresses are physical, so two agents that map one location at different virtual addresses still conflict. Addresses are compared per 8-byte granule.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is not armed (`mon_armed`=0) and no store-exclusive response is signalled (`stx_rsp_valid`=0).
- R2: A load-exclusive arms the reservation one cycle later and records its granule. A further load-exclusive replaces the recorded granule, so only the newer granule can then succeed.
- R3: A store-exclusive that arrives while the reservation is armed for its granule gives `stx_rsp_valid`=1, `stx_status`=0 (success) and `stx_wr_en`=1 in the next cycle.
- R4: A store-exclusive gives `stx_status`=1 (failure) and `stx_wr_en`=0 in the next cycle in either of two cases: no reservation is armed, or the reservation holds a different granule.
- R5: A store-exclusive disarms the reservation, whether it succeeds or fails.
- R6: A taken interrupt, an exception return or an explicit clear request disarms the reservation. A store-exclusive in the same cycle as one of these events fails.
- R7: A snooped write from another agent whose granule matches the reservation disarms it. A snooped write to another granule leaves it armed.
- R8: An ordinary local store, even one to the reserved granule, leaves the reservation armed.
- R9: Granules are 8 bytes. Address bits [2:0] are ignored when addresses are compared.
- R10: A load-exclusive in the same cycle as any disarming event leaves the reservation armed with the new granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldx_valid | input | 1 | Load-exclusive request |
| ldx_addr | input | ADDR_W | Physical address of the load-exclusive |
| stx_valid | input | 1 | Store-exclusive request |
| stx_addr | input | ADDR_W | Physical address of the store-exclusive |
| st_valid | input | 1 | Ordinary local store |
| st_addr | input | ADDR_W | Address of the ordinary store |
| irq_taken | input | 1 | Interrupt taken this cycle |
| exc_return | input | 1 | Exception return this cycle |
| clr_req | input | 1 | Explicit reservation clear |
| snoop_valid | input | 1 | Write observed from another agent |
| snoop_addr | input | ADDR_W | Physical address of the observed write |
| mon_armed | output | 1 | Reservation currently armed |
| stx_rsp_valid | output | 1 | Store-exclusive response valid |
| stx_status | output | 1 | 0 = success, 1 = failure |
| stx_wr_en | output | 1 | Memory side must perform the write |

## Verification
Every result passes through exactly one register. The store-exclusive response and write enable appear in the cycle after the request, and `mon_armed` reflects an event one cycle after that event. The bench drives each stimulus on a falling edge and holds it across one rising edge. It samples at the next falling edge and removes the stimulus before the following rising edge. Because of this, each check sees the result of exactly one request. A following idle cycle confirms that the response pulse lasts one cycle.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;
    localparam logic STX_PASS = 1'b0;
    localparam logic STX_FAIL = 1'b1;
    localparam int unsigned DEF_ADDR_W    = 40;
    localparam int unsigned DEF_GRAN_LOG2 = 3;
endpackage

// File: rtl/excl_granule_cmp.sv
module excl_granule_cmp #(
    parameter int unsigned ADDR_W    = 40,
    parameter int unsigned GRAN_LOG2 = 3,
    localparam int unsigned TAG_W    = ADDR_W - GRAN_LOG2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  tag,
    output logic              hit
);
    always_comb begin
        hit = (addr[ADDR_W-1:GRAN_LOG2] == tag);
    end
endmodule

// File: rtl/excl_clear_ctl.sv
module excl_clear_ctl (
    input  logic irq_taken,
    input  logic exc_return,
    input  logic clr_req,
    input  logic snoop_valid,
    input  logic snoop_hit,
    input  logic stx_valid,
    output logic evt_break,
    output logic disarm
);
    always_comb begin
        evt_break = irq_taken | exc_return | clr_req | (snoop_valid & snoop_hit);
        disarm    = evt_break | stx_valid;
    end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_monitor_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned GRAN_LOG2 = DEF_GRAN_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ldx_valid,
    input  logic [ADDR_W-1:0] ldx_addr,
    input  logic              stx_valid,
    input  logic [ADDR_W-1:0] stx_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              irq_taken,
    input  logic              exc_return,
    input  logic              clr_req,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              mon_armed,
    output logic              stx_rsp_valid,
    output logic              stx_status,
    output logic              stx_wr_en
);
    localparam int unsigned TAG_W = ADDR_W - GRAN_LOG2;

    typedef struct packed {
        logic             armed;
        logic [TAG_W-1:0] tag;
        logic             rsp_valid;
        logic             rsp_status;
        logic             wr_en;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic stx_hit, snoop_hit, evt_break, disarm, stx_ok;

    // Local stores never disturb the reservation (R8); only snooped writes do.
    logic unused_local;
    assign unused_local = st_valid ^ (^st_addr);

    excl_granule_cmp #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_stx_cmp (
        .addr (stx_addr),
        .tag  (st_q.tag),
        .hit  (stx_hit)
    );

    excl_granule_cmp #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_snoop_cmp (
        .addr (snoop_addr),
        .tag  (st_q.tag),
        .hit  (snoop_hit)
    );

    excl_clear_ctl u_clear (
        .irq_taken   (irq_taken),
        .exc_return  (exc_return),
        .clr_req     (clr_req),
        .snoop_valid (snoop_valid),
        .snoop_hit   (snoop_hit),
        .stx_valid   (stx_valid),
        .evt_break   (evt_break),
        .disarm      (disarm)
    );

    always_comb begin
        st_d   = st_q;
        stx_ok = st_q.armed & stx_hit & ~evt_break;

        st_d.rsp_valid  = stx_valid;
        st_d.rsp_status = stx_valid & ~stx_ok ? STX_FAIL : STX_PASS;
        st_d.wr_en      = stx_valid & stx_ok;

        if (ldx_valid) begin
            st_d.armed = 1'b1;
            st_d.tag   = ldx_addr[ADDR_W-1:GRAN_LOG2];
        end else if (disarm) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mon_armed     = st_q.armed;
    assign stx_rsp_valid = st_q.rsp_valid;
    assign stx_status    = st_q.rsp_status;
    assign stx_wr_en     = st_q.wr_en;

    p_ldx_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ldx_valid |=> mon_armed);

    p_pass_needs_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_rsp_valid && stx_status == STX_PASS) |-> $past(st_q.armed));

    p_unarmed_fails_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_valid && !st_q.armed) |=> (stx_rsp_valid && stx_status == STX_FAIL && !stx_wr_en));

    p_stx_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_valid && !ldx_valid) |=> !mon_armed);

    p_event_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_taken || exc_return || clr_req) && !ldx_valid) |=> !mon_armed);

    p_event_fails_stx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_valid && (irq_taken || exc_return || clr_req)) |=> !stx_wr_en);

    p_local_store_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_armed && st_valid && !stx_valid && !irq_taken && !exc_return
         && !clr_req && !snoop_valid) |=> mon_armed);

    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !stx_valid |=> !stx_rsp_valid);
endmodule

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ldx_valid, stx_valid, st_valid, irq_taken, exc_return, clr_req, snoop_valid;
    logic [AW-1:0] ldx_addr, stx_addr, st_addr, snoop_addr;
    logic mon_armed, stx_rsp_valid, stx_status, stx_wr_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    excl_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .ldx_valid(ldx_valid), .ldx_addr(ldx_addr),
        .stx_valid(stx_valid), .stx_addr(stx_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .irq_taken(irq_taken), .exc_return(exc_return), .clr_req(clr_req),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .mon_armed(mon_armed), .stx_rsp_valid(stx_rsp_valid),
        .stx_status(stx_status), .stx_wr_en(stx_wr_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_in();
        ldx_valid = 0; stx_valid = 0; st_valid = 0; irq_taken = 0;
        exc_return = 0; clr_req = 0; snoop_valid = 0;
        ldx_addr = '0; stx_addr = '0; st_addr = '0; snoop_addr = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_ldx(input logic [AW-1:0] a);
        ldx_valid = 1; ldx_addr = a;
        tick();
        clr_in();
    endtask

    task automatic chk_armed(input bit exp, input string req);
        check(mon_armed == exp, req, mon_armed, exp);
    endtask

    // stx in the current cycle (other inputs may be preset), response checked next cycle
    task automatic do_stx(input logic [AW-1:0] a, input bit exp_fail, input string req);
        stx_valid = 1; stx_addr = a;
        tick();
        clr_in();
        check(stx_rsp_valid == 1'b1, req, stx_rsp_valid, 1);
        check(stx_status == exp_fail, req, stx_status, exp_fail);
        check(stx_wr_en == !exp_fail, req, stx_wr_en, !exp_fail);
    endtask

    task automatic t_reset();
        chk_armed(0, "R1");
        check(stx_rsp_valid == 0, "R1", stx_rsp_valid, 0);
    endtask

    task automatic t_basic();
        do_ldx(40'h1000);
        chk_armed(1, "R2");
        do_stx(40'h1000, 0, "R3");
        chk_armed(0, "R5");
        tick();
        check(stx_rsp_valid == 0, "R3 pulse", stx_rsp_valid, 0);
    endtask

    task automatic t_fail_cases();
        do_stx(40'h2000, 1, "R4 unarmed");
        do_ldx(40'h2000);
        do_stx(40'h3000, 1, "R4 mismatch");
        chk_armed(0, "R5 after fail");
        do_stx(40'h2000, 1, "R5 retry fails");
    endtask

    task automatic t_granule();
        do_ldx(40'h4000);
        do_stx(40'h4007, 0, "R9 same granule");
        do_ldx(40'h4003);
        do_stx(40'h4008, 1, "R9 next granule");
    endtask

    task automatic t_events();
        for (int k = 0; k < 3; k++) begin
            do_ldx(40'h5000);
            irq_taken = (k == 0); exc_return = (k == 1); clr_req = (k == 2);
            tick();
            clr_in();
            chk_armed(0, "R6 event");
            do_stx(40'h5000, 1, "R6 stx after event");
        end
        do_ldx(40'h5000);
        irq_taken = 1;
        do_stx(40'h5000, 1, "R6 same cycle");
    endtask

    task automatic t_snoop();
        do_ldx(40'h6000);
        snoop_valid = 1; snoop_addr = 40'h6008;
        tick(); clr_in();
        chk_armed(1, "R7 miss");
        snoop_valid = 1; snoop_addr = 40'h6004;
        tick(); clr_in();
        chk_armed(0, "R7 hit");
        do_stx(40'h6000, 1, "R7 stx after hit");
    endtask

    task automatic t_local_store();
        do_ldx(40'h7000);
        st_valid = 1; st_addr = 40'h7000;
        tick(); clr_in();
        chk_armed(1, "R8");
        do_stx(40'h7000, 0, "R8 stx");
    endtask

    task automatic t_replace();
        do_ldx(40'h8000);
        do_ldx(40'h9000);
        do_stx(40'h8000, 1, "R2 old granule");
        do_ldx(40'h8000);
        do_ldx(40'h9000);
        do_stx(40'h9000, 0, "R2 new granule");
    endtask

    task automatic t_ldx_wins();
        ldx_valid = 1; ldx_addr = 40'hA000; irq_taken = 1;
        tick(); clr_in();
        chk_armed(1, "R10 irq");
        ldx_valid = 1; ldx_addr = 40'hB000; stx_valid = 1; stx_addr = 40'hA000;
        tick(); clr_in();
        chk_armed(1, "R10 stx");
        check(stx_status == 0 && stx_wr_en == 1, "R10 stx result", stx_wr_en, 1);
        do_stx(40'hB000, 0, "R10 new granule");
    endtask

    initial begin
        clr_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_fail_cases();
        t_granule();
        t_events();
        t_snoop();
        t_local_store();
        t_replace();
        t_ldx_wins();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                failures++; checks++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule